// File: doc/BRIEF.md
# Filtered Multi-Source Reset Controller

This block merges four reset requests into one stretched, clock-synchronous reset for a small microcontroller core, plus a separate reset for a companion coprocessor. The requests are an external active-low pin, a power-on pulse, a watchdog timeout pulse and a stop-mode recovery pulse. The external pin passes through a synchronizer and a glitch filter. A short low excursion on the pin never reaches the core. The coprocessor, by contrast, sees every synchronized low sample.

Once a reset has been taken, it is held for a minimum number of cycles, or for as long as the pin stays low, whichever ends later. During a power-on or watchdog reset the block asks the pad to pull the shared pin low, through an open-drain enable, for a parameterized time. A one-hot cause register records the source of the last reset. A preserve flag tells configuration logic that the last reset came from stop-mode recovery, so that its mode registers must be kept. After each release the block issues a boot-fetch strobe with a start address to each processor.

Top module: `multi_reset_ctrl`

## Requirements
- R1: With the defaults (SYNC_STAGES=2, FILT_CNT=4), a low on pin_ni held for 4 or fewer consecutive rising edges produces no core reset and leaves cause_o unchanged. A low held for 5 or more edges produces a core reset.
- R2: When the pin is first sampled low at edge e0 and stays low, core_rst_o is high after edge e6 and low before it.
- R3: A pin reset held low for N edges (N≥5) keeps core_rst_o high for max(HOLD_CYC, N-4) cycles, with HOLD_CYC=18.
- R4: A power-on or watchdog pulse sets pin_oe_o high for exactly POR_CYC=24 cycles. When the pin is wired back as pin = drive AND NOT pin_oe_o, core_rst_o stays high for POR_CYC+3 = 27 cycles.
- R5: A power-on pulse during an active reset restarts both the pin drive and the stretch, and sets the cause to power-on. Watchdog, stop-recovery and pin requests that arrive while core_rst_o is high are ignored, and cause_o does not change.
- R6: Requests that arrive on the same edge are ranked power-on, then watchdog, then stop-recovery, then pin.
- R7: cause_o is one-hot, with bit0 = pin, bit1 = power-on, bit2 = watchdog and bit3 = stop-recovery. It keeps its value after release until the next reset is taken.
- R8: A stop-recovery pulse gives an 18-cycle reset with no pin drive. preserve_o is high exactly when the last reset came from stop-recovery.
- R9: core_fetch_o is a one-cycle pulse FETCH_DLY=6 cycles after core_rst_o falls, with core_vec_o = 0x000C. core_vec_o is zero at all other times.
- R10: cop_rst_o is high in every cycle in which the synchronized pin is low or core_rst_o is high. A pin low held for N<5 edges gives an N-cycle coprocessor reset.
- R11: cop_fetch_o pulses in the first cycle in which cop_rst_o is low, with cop_vec_o = 0x0FFC. cop_vec_o is zero at all other times.
- R12: While rst_ni is low, core_rst_o=1, pin_oe_o=0 and cause_o=0. After rst_ni rises, core_rst_o stays high for HOLD_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the controller itself |
| pin_ni | input | 1 | Level on the shared reset pin (asynchronous) |
| por_i | input | 1 | Power-on request pulse |
| wdt_i | input | 1 | Watchdog timeout pulse |
| smr_i | input | 1 | Stop-mode recovery pulse |
| pin_oe_o | output | 1 | Open-drain pull-low enable for the shared pin |
| core_rst_o | output | 1 | Stretched reset for the main core |
| cop_rst_o | output | 1 | Reset for the coprocessor |
| cause_o | output | 4 | One-hot cause of the last reset |
| preserve_o | output | 1 | Last reset was stop-recovery; keep mode registers |
| core_fetch_o | output | 1 | Boot-fetch strobe for the main core |
| core_vec_o | output | 16 | Main-core start address, valid with its strobe |
| cop_fetch_o | output | 1 | Boot-fetch strobe for the coprocessor |
| cop_vec_o | output | 16 | Coprocessor start address, valid with its strobe |

## Verification
Every result has a fixed latency, counted from the edge at which the stimulus is sampled:
- A pin-driven reset rises six edges after the first low sample and falls two edges after the pin returns high, unless the minimum hold has not yet run out.
- A pulse-driven reset rises on the edge that samples the pulse.
- The main-core fetch strobe comes FETCH_DLY cycles after release.
- The coprocessor strobe comes in the first low cycle of cop_rst_o.

The bench drives inputs on falling edges and indexes each falling-edge sample from the edge that took the stimulus. It then compares run lengths, first-high indices and strobe positions with values computed from these counts. For the power-on and watchdog cases, the pin is fed back through the drive enable, so the three extra synchronizer cycles are part of the expected length.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int NSRC = 4;
  typedef enum logic [1:0] {SRC_EXT = 2'd0, SRC_POR = 2'd1, SRC_WDT = 2'd2, SRC_SMR = 2'd3} src_e;

  function automatic logic [NSRC-1:0] src_bit(src_e s);
    logic [NSRC-1:0] v;
    v = '0;
    v[s] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/rstc_pin_filter.sv
module rstc_pin_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CNT    = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  input  logic clr_i,
  output logic low_o,
  output logic trig_o
);
  localparam int CW = $clog2(FILT_CNT + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[0] <= 1'b1;
        else         sync_q[0] <= pin_ni;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[i] <= 1'b1;
        else         sync_q[i] <= sync_q[i-1];
    end
  end

  assign low_o = ~sync_q[SYNC_STAGES-1];

  // counts consecutive low samples; any high sample or active reset clears it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clr_i || !low_o)          cnt_q <= '0;
    else if (cnt_q != CW'(FILT_CNT))   cnt_q <= cnt_q + 1'b1;
  end

  // latch on the sample after FILT_CNT lows
  assign trig_o = low_o && !clr_i && (cnt_q == CW'(FILT_CNT));

  assert_filter_run_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> ($past(low_o) && $past(low_o, 2) && $past(low_o, 3)));
endmodule

// File: rtl/rstc_stretch.sv
module rstc_stretch
  import rstc_pkg::*;
#(
  parameter int HOLD_CYC = 18,
  parameter int POR_CYC  = 24
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ext_trig_i,
  input  logic            ext_low_i,
  input  logic            por_i,
  input  logic            wdt_i,
  input  logic            smr_i,
  output logic            core_rst_o,
  output logic            pin_oe_o,
  output logic [NSRC-1:0] cause_o
);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam int PW = $clog2(POR_CYC + 1);
  localparam int RW = $clog2(HOLD_CYC + 2) + 1;

  logic            rst_q, oe_q;
  logic [HW-1:0]   hold_q;
  logic [PW-1:0]   drv_q;
  logic [NSRC-1:0] cause_q;
  logic            start, drive;
  src_e            src;

  always_comb begin
    start = 1'b0;
    drive = 1'b0;
    src   = SRC_EXT;
    if (por_i) begin
      start = 1'b1; drive = 1'b1; src = SRC_POR;
    end else if (!rst_q) begin
      if (wdt_i) begin
        start = 1'b1; drive = 1'b1; src = SRC_WDT;
      end else if (smr_i) begin
        start = 1'b1; src = SRC_SMR;
      end else if (ext_trig_i) begin
        start = 1'b1; src = SRC_EXT;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q   <= 1'b1;
      hold_q  <= HW'(HOLD_CYC);
      oe_q    <= 1'b0;
      drv_q   <= '0;
      cause_q <= '0;
    end else if (start) begin
      rst_q   <= 1'b1;
      hold_q  <= HW'(HOLD_CYC - 1);
      cause_q <= src_bit(src);
      if (drive) begin
        oe_q  <= 1'b1;
        drv_q <= PW'(POR_CYC - 1);
      end
    end else if (rst_q) begin
      if (hold_q != '0) hold_q <= hold_q - 1'b1;
      if (oe_q) begin
        if (drv_q == '0) oe_q  <= 1'b0;
        else             drv_q <= drv_q - 1'b1;
      end
      if (hold_q == '0 && !oe_q && !ext_low_i) rst_q <= 1'b0;
    end
  end

  assign core_rst_o = rst_q;
  assign pin_oe_o   = oe_q;
  assign cause_o    = cause_q;

  // length of the current reset, for the minimum-hold check
  logic [RW-1:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           run_q <= RW'(1);
    else if (!rst_q)       run_q <= RW'(1);
    else if (run_q != '1)  run_q <= run_q + 1'b1;
  end

  assert_min_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_q) |-> ($past(run_q) >= RW'(HOLD_CYC)));
  assert_oe_in_rst_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_q |-> rst_q);
  assert_por_restart_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> (rst_q && oe_q && cause_q == src_bit(SRC_POR)));
  assert_busy_ignore_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_q && !por_i) |=> $stable(cause_q));
  assert_wdt_rank_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rst_q && wdt_i && !por_i) |=> (cause_q == src_bit(SRC_WDT) && oe_q));
  assert_cause_onehot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cause_q));
  assert_smr_no_drive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smr_i && !rst_q && !por_i && !wdt_i) |=> (!oe_q && cause_q == src_bit(SRC_SMR)));
endmodule

// File: rtl/rstc_boot_seq.sv
module rstc_boot_seq #(
  parameter int          FETCH_DLY = 6,
  parameter int          AW        = 16,
  parameter logic [15:0] CORE_VEC  = 16'h000C,
  parameter logic [15:0] COP_VEC   = 16'h0FFC
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          core_rst_i,
  input  logic          cop_rst_i,
  output logic          core_fetch_o,
  output logic [AW-1:0] core_vec_o,
  output logic          cop_fetch_o,
  output logic [AW-1:0] cop_vec_o
);
  localparam int FW = $clog2(FETCH_DLY + 1);

  logic          prev_q, armed_q, fetch_q, cop_q;
  logic [FW-1:0] fcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b1;
      armed_q <= 1'b0;
      fetch_q <= 1'b0;
      fcnt_q  <= '0;
      cop_q   <= 1'b1;
    end else begin
      prev_q  <= core_rst_i;
      cop_q   <= cop_rst_i;
      fetch_q <= 1'b0;
      if (core_rst_i) begin
        armed_q <= 1'b0;
      end else if (prev_q) begin
        // first edge after release: one cycle of the delay already spent
        armed_q <= 1'b1;
        fcnt_q  <= FW'(FETCH_DLY - 2);
      end else if (armed_q) begin
        if (fcnt_q == '0) begin
          fetch_q <= 1'b1;
          armed_q <= 1'b0;
        end else begin
          fcnt_q <= fcnt_q - 1'b1;
        end
      end
    end
  end

  assign core_fetch_o = fetch_q;
  assign core_vec_o   = fetch_q ? AW'(CORE_VEC) : '0;
  assign cop_fetch_o  = cop_q & ~cop_rst_i;
  assign cop_vec_o    = cop_fetch_o ? AW'(COP_VEC) : '0;

  assert_core_fetch_gap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_fetch_o |-> ($past(core_rst_i, FETCH_DLY + 1) && !$past(core_rst_i, FETCH_DLY)));
  assert_core_fetch_vec_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_fetch_o |-> (!core_rst_i && core_vec_o == AW'(CORE_VEC)));
  assert_cop_fetch_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cop_fetch_o |-> ($past(cop_rst_i) && !cop_rst_i && cop_vec_o == AW'(COP_VEC)));
endmodule

// File: rtl/multi_reset_ctrl.sv
module multi_reset_ctrl
  import rstc_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter int          FILT_CNT    = 4,
  parameter int          HOLD_CYC    = 18,
  parameter int          POR_CYC     = 24,
  parameter int          FETCH_DLY   = 6,
  parameter int          AW          = 16,
  parameter logic [15:0] CORE_VEC    = 16'h000C,
  parameter logic [15:0] COP_VEC     = 16'h0FFC
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pin_ni,
  input  logic            por_i,
  input  logic            wdt_i,
  input  logic            smr_i,
  output logic            pin_oe_o,
  output logic            core_rst_o,
  output logic            cop_rst_o,
  output logic [NSRC-1:0] cause_o,
  output logic            preserve_o,
  output logic            core_fetch_o,
  output logic [AW-1:0]   core_vec_o,
  output logic            cop_fetch_o,
  output logic [AW-1:0]   cop_vec_o
);
  logic ext_low, ext_trig, core_rst;

  rstc_pin_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_CNT(FILT_CNT)) u_filter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_ni (pin_ni),
    .clr_i  (core_rst),
    .low_o  (ext_low),
    .trig_o (ext_trig)
  );

  rstc_stretch #(.HOLD_CYC(HOLD_CYC), .POR_CYC(POR_CYC)) u_stretch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ext_trig_i (ext_trig),
    .ext_low_i  (ext_low),
    .por_i      (por_i),
    .wdt_i      (wdt_i),
    .smr_i      (smr_i),
    .core_rst_o (core_rst),
    .pin_oe_o   (pin_oe_o),
    .cause_o    (cause_o)
  );

  assign core_rst_o = core_rst;
  assign cop_rst_o  = core_rst | ext_low;
  assign preserve_o = cause_o[SRC_SMR];

  rstc_boot_seq #(.FETCH_DLY(FETCH_DLY), .AW(AW), .CORE_VEC(CORE_VEC), .COP_VEC(COP_VEC)) u_boot (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .core_rst_i   (core_rst),
    .cop_rst_i    (cop_rst_o),
    .core_fetch_o (core_fetch_o),
    .core_vec_o   (core_vec_o),
    .cop_fetch_o  (cop_fetch_o),
    .cop_vec_o    (cop_vec_o)
  );

  assert_ext_two_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(core_rst) && cause_o == src_bit(SRC_EXT)) |-> ($past(ext_low) && $past(ext_low, 2)));
  assert_cop_follows_core_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_rst_o) |-> cop_rst_o);
endmodule

// File: tb/multi_reset_ctrl_test.sv
module multi_reset_ctrl_test;
  localparam int HOLD = 18;
  localparam int PORT = 24;
  localparam int FDLY = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin_drv = 1'b1;
  logic        por = 1'b0, wdt = 1'b0, smr = 1'b0;
  logic        pin_oe_o, core_rst_o, cop_rst_o, preserve_o, core_fetch_o, cop_fetch_o;
  logic [3:0]  cause_o;
  logic [15:0] core_vec_o, cop_vec_o;
  wire         pin_w = pin_drv & ~pin_oe_o;

  int total = 0;
  int fails = 0;

  always #4 clk = ~clk;

  multi_reset_ctrl #(.SYNC_STAGES(2), .FILT_CNT(4), .HOLD_CYC(HOLD), .POR_CYC(PORT),
                     .FETCH_DLY(FDLY)) uut (
    .clk_i(clk), .rst_ni(rst_n), .pin_ni(pin_w), .por_i(por), .wdt_i(wdt), .smr_i(smr),
    .pin_oe_o(pin_oe_o), .core_rst_o(core_rst_o), .cop_rst_o(cop_rst_o), .cause_o(cause_o),
    .preserve_o(preserve_o), .core_fetch_o(core_fetch_o), .core_vec_o(core_vec_o),
    .cop_fetch_o(cop_fetch_o), .cop_vec_o(cop_vec_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // strobe monitor: R9 and R11
  int   since = -1;
  logic prev_core = 1'b1, prev_cop = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (core_rst_o)     since = -1;
      else if (prev_core) since = 0;
      else if (since >= 0) since++;
      if (core_fetch_o) begin
        check(since == FDLY, "R9 fetch delay", since, FDLY);
        check(core_vec_o == 16'h000C, "R9 core vector", core_vec_o, 16'h000C);
      end else begin
        if (core_vec_o != 16'h0) check(0, "R9 idle vector", core_vec_o, 0);
      end
      if (prev_cop && !cop_rst_o) begin
        check(cop_fetch_o == 1'b1, "R11 cop strobe", cop_fetch_o, 1);
        check(cop_vec_o == 16'h0FFC, "R11 cop vector", cop_vec_o, 16'h0FFC);
      end else if (cop_fetch_o || cop_vec_o != 16'h0) begin
        check(0, "R11 stray cop strobe", cop_fetch_o, 0);
      end
      prev_core = core_rst_o;
      prev_cop  = cop_rst_o;
    end
  end

  // src bits {smr,wdt,por}; late_src sampled late_at edges after the first
  task automatic measure(input logic [2:0] first_src, input logic [2:0] late_src,
                         input int late_at, output int core_hi, output int oe_hi);
    {smr, wdt, por} = first_src;
    core_hi = 0;
    oe_hi = 0;
    for (int k = 0; k < 70; k++) begin
      @(negedge clk);
      core_hi += int'(core_rst_o);
      oe_hi   += int'(pin_oe_o);
      {smr, wdt, por} = (late_at > 0 && k == late_at - 1) ? late_src : 3'b000;
    end
  endtask

  task automatic ext_pulse(input int n, output int first_hi, output int core_hi, output int cop_hi);
    pin_drv = 1'b0;
    first_hi = -1;
    core_hi = 0;
    cop_hi = 0;
    for (int k = 0; k < n + 45; k++) begin
      @(negedge clk);
      if (core_rst_o && first_hi < 0) first_hi = k;
      core_hi += int'(core_rst_o);
      cop_hi  += int'(cop_rst_o);
      if (k == n - 1) pin_drv = 1'b1;
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin : main
    int c, o, f, p;
    logic [3:0] prev_cause;
    repeat (3) @(negedge clk);
    // R12 reset state
    check(core_rst_o == 1'b1, "R12 core in reset", core_rst_o, 1);
    check(pin_oe_o == 1'b0, "R12 oe in reset", pin_oe_o, 0);
    check(cause_o == 4'b0000, "R12 cause in reset", cause_o, 0);
    rst_n = 1'b1;
    c = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      c += int'(core_rst_o);
    end
    check(c == HOLD, "R12 release length", c, HOLD);

    // R1 R2 R3 R10 sweep of pin low widths
    for (int n = 1; n <= 30; n++) begin
      prev_cause = cause_o;
      ext_pulse(n, f, c, p);
      if (n < 5) begin
        check(c == 0, "R1 short pulse ignored", c, 0);
        check(cause_o == prev_cause, "R1 cause kept", cause_o, prev_cause);
        check(p == n, "R10 cop reset width", p, n);
      end else begin
        check(f == 6, "R2 latch edge", f, 6);
        check(c == ((n - 4) > HOLD ? n - 4 : HOLD), "R3 stretch length", c,
              (n - 4) > HOLD ? n - 4 : HOLD);
        check(cause_o == 4'b0001, "R7 pin cause", cause_o, 1);
      end
    end

    // R4 power-on
    measure(3'b001, 3'b000, 0, c, o);
    check(c == PORT + 3, "R4 por length", c, PORT + 3);
    check(o == PORT, "R4 por drive", o, PORT);
    check(cause_o == 4'b0010, "R7 por cause", cause_o, 2);
    check(preserve_o == 1'b0, "R8 no preserve after por", preserve_o, 0);

    // R4 watchdog
    measure(3'b010, 3'b000, 0, c, o);
    check(c == PORT + 3, "R4 wdt length", c, PORT + 3);
    check(o == PORT, "R4 wdt drive", o, PORT);
    check(cause_o == 4'b0100, "R7 wdt cause", cause_o, 4);

    // R8 stop recovery
    measure(3'b100, 3'b000, 0, c, o);
    check(c == HOLD, "R8 smr length", c, HOLD);
    check(o == 0, "R8 smr no drive", o, 0);
    check(cause_o == 4'b1000, "R8 smr cause", cause_o, 8);
    check(preserve_o == 1'b1, "R8 preserve set", preserve_o, 1);

    // R5 watchdog during reset ignored
    measure(3'b100, 3'b010, 5, c, o);
    check(c == HOLD, "R5 wdt ignored length", c, HOLD);
    check(o == 0, "R5 wdt ignored drive", o, 0);
    check(cause_o == 4'b1000, "R5 wdt ignored cause", cause_o, 8);

    // R8 pin reset clears preserve
    ext_pulse(10, f, c, p);
    check(preserve_o == 1'b0, "R8 preserve cleared", preserve_o, 0);

    // R5 power-on restarts a watchdog reset
    measure(3'b010, 3'b001, 10, c, o);
    check(c == 10 + PORT + 3, "R5 restart length", c, 10 + PORT + 3);
    check(o == 10 + PORT, "R5 restart drive", o, 10 + PORT);
    check(cause_o == 4'b0010, "R5 restart cause", cause_o, 2);

    // R5 power-on restarts a stop-recovery reset
    measure(3'b100, 3'b001, 5, c, o);
    check(c == 5 + PORT + 3, "R5 smr restart length", c, 5 + PORT + 3);
    check(o == PORT, "R5 smr restart drive", o, PORT);
    check(preserve_o == 1'b0, "R8 preserve after restart", preserve_o, 0);

    // R6 ranking
    measure(3'b111, 3'b000, 0, c, o);
    check(cause_o == 4'b0010, "R6 por wins", cause_o, 2);
    measure(3'b110, 3'b000, 0, c, o);
    check(cause_o == 4'b0100, "R6 wdt over smr", cause_o, 4);
    check(c == PORT + 3, "R6 wdt length", c, PORT + 3);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule